// File: doc/BRIEF.md
# Asynchronous Serial Framing Core

This block turns characters into asynchronous serial frames and back. A transmit path takes a character from a one-entry transmit buffer and shifts it out on `txd_o`, least significant bit first. The frame is a low start bit, then the data bits, then an optional parity bit, then one or two high stop bits. A receive path watches `rxd_i`, checks each frame and places the character in a receive buffer. Bit timing comes from an external enable, `tick16_i`, which pulses sixteen times per bit. Each bit therefore lasts sixteen ticks.

Software sets the format through a 7-bit control word: frame mode, stop count, parity enable, parity sense and the error-detection enables. The 11-bit read view of the control word adds the receiver-enable state and three sticky error flags. These extra bits can change only through a separate write-only set/clear register. That register also turns the receiver on and off. Single-cycle status pulses report four events: the transmit buffer moving into the shifter, the end of a transmitted frame, a received character, and a newly raised error flag.

Top module: `serial_frame_core`

## Requirements
- R1: After reset `txd_o` is high, `ctrl_rdata_o` reads 0 (receiver off, flags clear), `rbuf_rdata_o` reads 0 and no status pulse is active.
- R2: Control bits [1:0] select the frame mode. 00 is 8 data bits with no parity, 01 is 7 data bits plus parity, 10 is 8 data bits plus parity, and 11 behaves as 00. Every frame bit lasts 16 ticks, with the start bit low and the data sent LSB first.
- R3: Control bit 2 set sends two high stop bits. Clear sends one.
- R4: In both parity modes a parity bit follows the data. With control bit 4 clear, the data bits and the parity bit together hold an even number of ones. With bit 4 set they hold an odd number.
- R5: A written character moves into the idle shifter and `tx_empty_o` pulses once at that move. A character written during a frame waits until the frame ends. `tx_done_o` pulses once after the last stop bit.
- R6: The receiver is off after reset. Set/clear bit 0 turns it on and bit 1 turns it off. The state reads back at control bit 7. While the receiver is off, frames are ignored.
- R7: The receiver confirms the start bit 8 ticks after the falling edge. It then samples each bit 16 ticks apart. On the last stop sample it stores the character and pulses `rx_done_o`. In mode 01 the stored bit 7 reads 0.
- R8: With control bit 3 set in a parity mode, a received parity bit that breaks the selected sense raises the parity flag at control bit 9.
- R9: A stop bit sampled low raises the framing flag at control bit 8, but only while control bit 5 is set.
- R10: A character that completes while the receive buffer is unread raises the overrun flag at control bit 10, but only while control bit 6 is set. The new character replaces the old one. A buffer read in the completion cycle counts as a read.
- R11: The error flags stay set until set/clear bit 2 (framing), bit 3 (parity) or bit 4 (overrun) is written. A control-word write changes only bits 6:0.
- R12: `err_o` pulses for one cycle whenever an enabled error flag is newly raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Oversampling enable, 16 per bit |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 7 | Control word write data |
| ctrl_rdata_o | output | 11 | Control word read view: config, receiver enable, flags |
| setclr_we_i | input | 1 | Set/clear register write strobe |
| setclr_wdata_i | input | 5 | Set/clear bits: rx on, rx off, clear framing, clear parity, clear overrun |
| tbuf_we_i | input | 1 | Transmit buffer write strobe |
| tbuf_wdata_i | input | 8 | Transmit character |
| rbuf_re_i | input | 1 | Receive buffer read strobe |
| rbuf_rdata_o | output | 8 | Received character |
| rxd_i | input | 1 | Serial input |
| txd_o | output | 1 | Serial output |
| tx_empty_o | output | 1 | Pulse: transmit buffer moved into the shifter |
| tx_done_o | output | 1 | Pulse: frame fully sent |
| rx_done_o | output | 1 | Pulse: character received |
| err_o | output | 1 | Pulse: an error flag was newly raised |

## Verification
Two events can land in the same cycle: the completion of a received character and a software read of the receive buffer. If the read is judged wrongly, the design reports an overrun that software never caused. The bench holds the read strobe high for two whole back-to-back frames, so a read is asserted in each completion cycle. It then expects the overrun flag to stay clear even though overrun detection is enabled. A separate run without reads expects the flag to rise and the second character to replace the first.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int CHAR_W  = 8;
  localparam int CFG_W   = 7;
  localparam int RD_W    = CFG_W + 4;
  localparam int SC_W    = 5;
  localparam int FRAME_W = 1 + CHAR_W + 1 + 2;

  typedef enum logic [1:0] {
    MODE_8N  = 2'b00,
    MODE_7P  = 2'b01,
    MODE_8P  = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_e;

  // control word bit positions
  localparam int B_STP = 2;
  localparam int B_PEN = 3;
  localparam int B_ODD = 4;
  localparam int B_FEN = 5;
  localparam int B_OEN = 6;

  // set/clear register bit positions
  localparam int S_REN_SET = 0;
  localparam int S_REN_CLR = 1;
  localparam int S_FE_CLR  = 2;
  localparam int S_PE_CLR  = 3;
  localparam int S_OE_CLR  = 4;

  function automatic int data_bits(mode_e m);
    return (m == MODE_7P) ? CHAR_W - 1 : CHAR_W;
  endfunction

  function automatic logic has_parity(mode_e m);
    return (m == MODE_7P) || (m == MODE_8P);
  endfunction

  function automatic logic [CHAR_W-1:0] char_mask(mode_e m);
    return (m == MODE_7P) ? {1'b0, {(CHAR_W-1){1'b1}}} : {CHAR_W{1'b1}};
  endfunction
endpackage

// File: rtl/sfc_ctrl_regs.sv
module sfc_ctrl_regs
  import sfc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [CFG_W-1:0] ctrl_wdata_i,
  input  logic             sc_we_i,
  input  logic [SC_W-1:0]  sc_wdata_i,
  input  logic             fe_ev_i,
  input  logic             pe_ev_i,
  input  logic             oe_ev_i,
  output mode_e            mode_o,
  output logic             two_stop_o,
  output logic             odd_o,
  output logic             ren_o,
  output logic [RD_W-1:0]  rdata_o,
  output logic             err_o
);
  logic [CFG_W-1:0] cfg_q;
  logic ren_q, fe_q, pe_q, oe_q, err_q;
  logic fe_set, pe_set, oe_set;
  logic fe_clr, pe_clr, oe_clr;

  assign fe_set = fe_ev_i && cfg_q[B_FEN];
  assign pe_set = pe_ev_i && cfg_q[B_PEN];
  assign oe_set = oe_ev_i && cfg_q[B_OEN];
  assign fe_clr = sc_we_i && sc_wdata_i[S_FE_CLR];
  assign pe_clr = sc_we_i && sc_wdata_i[S_PE_CLR];
  assign oe_clr = sc_we_i && sc_wdata_i[S_OE_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ren_q <= 1'b0;
      fe_q  <= 1'b0;
      pe_q  <= 1'b0;
      oe_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (ctrl_we_i) cfg_q <= ctrl_wdata_i;
      if (sc_we_i && sc_wdata_i[S_REN_SET])      ren_q <= 1'b1;
      else if (sc_we_i && sc_wdata_i[S_REN_CLR]) ren_q <= 1'b0;
      // a new error wins over a clear in the same cycle
      if (fe_set) fe_q <= 1'b1; else if (fe_clr) fe_q <= 1'b0;
      if (pe_set) pe_q <= 1'b1; else if (pe_clr) pe_q <= 1'b0;
      if (oe_set) oe_q <= 1'b1; else if (oe_clr) oe_q <= 1'b0;
      err_q <= fe_set | pe_set | oe_set;
    end
  end

  assign mode_o     = mode_e'(cfg_q[1:0]);
  assign two_stop_o = cfg_q[B_STP];
  assign odd_o      = cfg_q[B_ODD];
  assign ren_o      = ren_q;
  assign rdata_o    = {oe_q, pe_q, fe_q, ren_q, cfg_q};
  assign err_o      = err_q;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_q && !pe_clr) |=> pe_q); // R11
  AST_ERR_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fe_q) || $rose(pe_q) || $rose(oe_q)) |-> err_o); // R12
  AST_REN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_we_i && sc_wdata_i[S_REN_SET]) |=> ren_q); // R6
  AST_FE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fe_q) |-> $past(cfg_q[B_FEN])); // R9
endmodule

// File: rtl/sfc_tx.sv
module sfc_tx
  import sfc_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  mode_e             mode_i,
  input  logic              two_stop_i,
  input  logic              odd_i,
  input  logic              buf_we_i,
  input  logic [CHAR_W-1:0] buf_data_i,
  output logic              txd_o,
  output logic              tbe_o,
  output logic              tc_o
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(FRAME_W + 1);

  logic [CHAR_W-1:0]  buf_q;
  logic               full_q, busy_q, tbe_q, tc_q;
  logic [FRAME_W-1:0] sh_q, frame_d;
  logic [BW-1:0]      left_q, nbits_d;
  logic [CW-1:0]      cnt_q;
  logic               load, par;
  int                 nd;
  logic               hp;

  assign load = !busy_q && full_q;
  assign par  = (^(buf_q & char_mask(mode_i))) ^ odd_i;

  always_comb begin
    nd = data_bits(mode_i);
    hp = has_parity(mode_i);
    frame_d = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < nd) frame_d[1+i] = buf_q[i];
    end
    if (hp) frame_d[1+nd] = par;
    nbits_d = BW'(2 + nd + int'(hp) + int'(two_stop_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
      tbe_q  <= 1'b0;
      tc_q   <= 1'b0;
    end else begin
      tbe_q <= 1'b0;
      tc_q  <= 1'b0;
      if (buf_we_i) begin
        buf_q  <= buf_data_i;
        full_q <= 1'b1;
      end else if (load) begin
        full_q <= 1'b0;
      end
      if (load) begin
        busy_q <= 1'b1;
        sh_q   <= frame_d;
        left_q <= nbits_d;
        cnt_q  <= '0;
        tbe_q  <= 1'b1;
      end else if (busy_q && tick_i) begin
        if (cnt_q == CW'(OVS - 1)) begin
          cnt_q  <= '0;
          sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
          left_q <= left_q - 1'b1;
          if (left_q == BW'(1)) begin
            busy_q <= 1'b0;
            tc_q   <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign txd_o = busy_q ? sh_q[0] : 1'b1;
  assign tbe_o = tbe_q;
  assign tc_o  = tc_q;

  AST_START_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbe_o |-> !txd_o); // R5
  AST_TC_TBE_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tc_o && tbe_o)); // R5
endmodule

// File: rtl/sfc_rx.sv
module sfc_rx
  import sfc_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  mode_e             mode_i,
  input  logic              two_stop_i,
  input  logic              odd_i,
  input  logic              rxd_i,
  input  logic              rd_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              rc_o,
  output logic              fe_ev_o,
  output logic              pe_ev_o,
  output logic              oe_ev_o
);
  localparam int CW   = $clog2(OVS);
  localparam int IW   = $clog2(FRAME_W + 1);
  localparam int HALF = OVS / 2;

  rx_st_e            st_q;
  logic [1:0]        sync_q;
  logic              rxd_s, armed_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [CHAR_W-1:0] shd_q, rbuf_q;
  logic              par_q, bad_q, full_q;
  logic              rc_q, fe_q, pe_q, oe_q;
  int                nd, total;
  logic              hp, samp, last;

  assign rxd_s = sync_q[1];

  always_comb begin
    nd    = data_bits(mode_i);
    hp    = has_parity(mode_i);
    total = nd + int'(hp) + 1 + int'(two_stop_i);
    samp  = (st_q == RX_BITS) && tick_i && (cnt_q == CW'(OVS - 1));
    last  = int'(idx_q) == total - 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      sync_q  <= 2'b11;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      shd_q   <= '0;
      rbuf_q  <= '0;
      par_q   <= 1'b0;
      bad_q   <= 1'b0;
      full_q  <= 1'b0;
      rc_q    <= 1'b0;
      fe_q    <= 1'b0;
      pe_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      rc_q <= 1'b0;
      fe_q <= 1'b0;
      pe_q <= 1'b0;
      oe_q <= 1'b0;
      if (samp && last) full_q <= 1'b1;
      else if (rd_i)    full_q <= 1'b0;
      if (!en_i) begin
        st_q    <= RX_IDLE;
        armed_q <= 1'b0;
      end else begin
        unique case (st_q)
          RX_IDLE: begin
            // new start only after the line has been seen high
            if (rxd_s) armed_q <= 1'b1;
            else if (tick_i && armed_q) begin
              st_q    <= RX_START;
              armed_q <= 1'b0;
              cnt_q   <= '0;
            end
          end
          RX_START: if (tick_i) begin
            if (cnt_q == CW'(HALF - 1)) begin
              if (!rxd_s) begin
                st_q  <= RX_BITS;
                cnt_q <= '0;
                idx_q <= '0;
                shd_q <= '0;
                bad_q <= 1'b0;
              end else begin
                st_q <= RX_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_BITS: if (tick_i) begin
            if (samp) begin
              cnt_q <= '0;
              idx_q <= idx_q + 1'b1;
              if (int'(idx_q) < nd)                 shd_q[idx_q[2:0]] <= rxd_s;
              else if (hp && int'(idx_q) == nd)     par_q <= rxd_s;
              else if (!rxd_s)                      bad_q <= 1'b1;
              if (last) begin
                st_q   <= RX_IDLE;
                rbuf_q <= shd_q & char_mask(mode_i);
                rc_q   <= 1'b1;
                fe_q   <= bad_q | !rxd_s;
                pe_q   <= hp && (par_q != ((^(shd_q & char_mask(mode_i))) ^ odd_i));
                oe_q   <= full_q && !rd_i;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign data_o  = rbuf_q;
  assign rc_o    = rc_q;
  assign fe_ev_o = fe_q;
  assign pe_ev_o = pe_q;
  assign oe_ev_o = oe_q;

  AST_RC_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rc_o |-> $past(en_i)); // R6
  AST_RBUF_7BIT_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rc_o && $past(mode_i) == MODE_7P) |-> !data_o[CHAR_W-1]); // R7
endmodule

// File: rtl/serial_frame_core.sv
module serial_frame_core
  import sfc_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              ctrl_we_i,
  input  logic [CFG_W-1:0]  ctrl_wdata_i,
  output logic [RD_W-1:0]   ctrl_rdata_o,
  input  logic              setclr_we_i,
  input  logic [SC_W-1:0]   setclr_wdata_i,
  input  logic              tbuf_we_i,
  input  logic [CHAR_W-1:0] tbuf_wdata_i,
  input  logic              rbuf_re_i,
  output logic [CHAR_W-1:0] rbuf_rdata_o,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              tx_empty_o,
  output logic              tx_done_o,
  output logic              rx_done_o,
  output logic              err_o
);
  mode_e mode;
  logic  two_stop, odd, ren;
  logic  fe_ev, pe_ev, oe_ev;

  sfc_ctrl_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_we_i   (ctrl_we_i),
    .ctrl_wdata_i(ctrl_wdata_i),
    .sc_we_i     (setclr_we_i),
    .sc_wdata_i  (setclr_wdata_i),
    .fe_ev_i     (fe_ev),
    .pe_ev_i     (pe_ev),
    .oe_ev_i     (oe_ev),
    .mode_o      (mode),
    .two_stop_o  (two_stop),
    .odd_o       (odd),
    .ren_o       (ren),
    .rdata_o     (ctrl_rdata_o),
    .err_o       (err_o)
  );

  sfc_tx #(.OVS(OVS)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick16_i),
    .mode_i    (mode),
    .two_stop_i(two_stop),
    .odd_i     (odd),
    .buf_we_i  (tbuf_we_i),
    .buf_data_i(tbuf_wdata_i),
    .txd_o     (txd_o),
    .tbe_o     (tx_empty_o),
    .tc_o      (tx_done_o)
  );

  sfc_rx #(.OVS(OVS)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick16_i),
    .en_i      (ren),
    .mode_i    (mode),
    .two_stop_i(two_stop),
    .odd_i     (odd),
    .rxd_i     (rxd_i),
    .rd_i      (rbuf_re_i),
    .data_o    (rbuf_rdata_o),
    .rc_o      (rx_done_o),
    .fe_ev_o   (fe_ev),
    .pe_ev_o   (pe_ev),
    .oe_ev_o   (oe_ev)
  );
endmodule

// File: tb/serial_frame_core_tb.sv
module serial_frame_core_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0;
  logic ctrl_we = 1'b0, sc_we = 1'b0, tb_we = 1'b0, rb_re = 1'b0, rxd = 1'b1;
  logic [6:0]  ctrl_wd = '0;
  logic [4:0]  sc_wd = '0;
  logic [7:0]  tb_wd = '0;
  logic [10:0] ctrl_rd;
  logic [7:0]  rb_rd;
  logic txd, tbe, tc, rc, err;
  int n_chk = 0, n_fail = 0, n_tbe = 0, n_tc = 0, n_rc = 0, n_err = 0, div = 0;
  logic [6:0] cur_cfg = '0;

  serial_frame_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick16),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd), .ctrl_rdata_o(ctrl_rd),
    .setclr_we_i(sc_we), .setclr_wdata_i(sc_wd),
    .tbuf_we_i(tb_we), .tbuf_wdata_i(tb_wd),
    .rbuf_re_i(rb_re), .rbuf_rdata_o(rb_rd),
    .rxd_i(rxd), .txd_o(txd),
    .tx_empty_o(tbe), .tx_done_o(tc), .rx_done_o(rc), .err_o(err)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tick16 = (div == 3);
    div = (div + 1) % 4;
    if (tbe) n_tbe++;
    if (tc)  n_tc++;
    if (rc)  n_rc++;
    if (err) n_err++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; ) begin
      @(posedge clk);
      if (tick16) k++;
    end
  endtask

  task automatic set_cfg(input int mode, input bit stp, pen, odd, fen, oen);
    @(negedge clk);
    cur_cfg = {oen, fen, odd, pen, stp, 2'(mode)};
    ctrl_wd = cur_cfg; ctrl_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic setclr(input logic [4:0] v);
    @(negedge clk);
    sc_wd = v; sc_we = 1'b1;
    @(negedge clk);
    sc_we = 1'b0;
  endtask

  task automatic build(ref bit q[$], input logic [7:0] d, input int mode,
                       input bit stp, odd, flip_par, bad_stop);
    int nd;
    bit p;
    q.delete();
    nd = (mode == 1) ? 7 : 8;
    p = odd;
    q.push_back(1'b0);
    for (int i = 0; i < nd; i++) begin
      q.push_back(d[i]);
      p ^= d[i];
    end
    if (mode == 1 || mode == 2) q.push_back(p ^ flip_par);
    q.push_back(!bad_stop);
    if (stp) q.push_back(1'b1);
  endtask

  task automatic wait_tbe(input string req);
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!tbe && t < 2000);
    check(tbe, req, 0, 1);
  endtask

  task automatic write_tbuf(input logic [7:0] d);
    @(negedge clk);
    tb_wd = d; tb_we = 1'b1;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic sample_tx(ref bit q[$], input string req);
    int bad = 0;
    for (int i = 0; i < q.size(); i++) begin
      wait_ticks(i == 0 ? 8 : 16);
      @(negedge clk);
      if (txd !== q[i]) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic tx_frame(input logic [7:0] d, input int mode, input bit stp, odd, input string req);
    bit q[$];
    int tc0;
    build(q, d, mode, stp, odd, 1'b0, 1'b0);
    tc0 = n_tc;
    write_tbuf(d);
    wait_tbe(req);
    sample_tx(q, req);
    wait_ticks(16);
    @(negedge clk);
    check(n_tc == tc0 + 1, "R5", n_tc - tc0, 1);
    check(txd === 1'b1, "R5", txd, 1);
  endtask

  task automatic rx_frame(input logic [7:0] d, input int mode, input bit stp, odd, flip_par, bad_stop);
    bit q[$];
    build(q, d, mode, stp, odd, flip_par, bad_stop);
    foreach (q[i]) begin
      @(negedge clk);
      rxd = q[i];
      wait_ticks(16);
    end
    @(negedge clk);
    rxd = 1'b1;
    wait_ticks(4);
    @(negedge clk);
  endtask

  task automatic read_rbuf();
    @(negedge clk);
    rb_re = 1'b1;
    @(negedge clk);
    rb_re = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    int c0, e0, t0;
    bit q[$], q2[$];
    repeat (3) @(negedge clk);
    check(txd === 1'b1, "R1", txd, 1);
    check(ctrl_rd == 11'h0, "R1", ctrl_rd, 0);
    check(rb_rd == 8'h0 && !tbe && !tc && !rc && !err, "R1", rb_rd, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // transmit: R2 R3 R4
    set_cfg(0, 0, 0, 0, 0, 0);
    check(ctrl_rd == 11'h000, "R2", ctrl_rd, 0);
    tx_frame(8'hA5, 0, 0, 0, "R2");
    set_cfg(1, 1, 0, 0, 0, 0);
    tx_frame(8'hD3, 1, 1, 0, "R3");
    set_cfg(2, 0, 0, 1, 0, 0);
    tx_frame(8'h0F, 2, 0, 1, "R4");
    set_cfg(1, 0, 0, 1, 0, 0);
    tx_frame(8'h6E, 1, 0, 1, "R4");
    set_cfg(3, 0, 0, 0, 0, 0);
    tx_frame(8'h81, 0, 0, 0, "R2");

    // back-to-back writes: R5
    set_cfg(0, 0, 0, 0, 0, 0);
    build(q, 8'h12, 0, 0, 0, 0, 0);
    build(q2, 8'hC4, 0, 0, 0, 0, 0);
    t0 = n_tbe; c0 = n_tc;
    write_tbuf(8'h12);
    wait_tbe("R5");
    write_tbuf(8'hC4);
    sample_tx(q, "R5");
    wait_tbe("R5");
    check(n_tc == c0 + 1, "R5", n_tc - c0, 1);
    sample_tx(q2, "R5");
    wait_ticks(16);
    @(negedge clk);
    check(n_tbe == t0 + 2 && n_tc == c0 + 2, "R5", n_tbe - t0, 2);

    // receiver off: R6
    c0 = n_rc;
    rx_frame(8'h55, 0, 0, 0, 0, 0);
    check(n_rc == c0 && rb_rd == 8'h00, "R6", n_rc - c0, 0);
    setclr(5'b00001);
    check(ctrl_rd[7] == 1'b1, "R6", ctrl_rd[7], 1);

    // receive: R7
    c0 = n_rc;
    rx_frame(8'h3C, 0, 0, 0, 0, 0);
    check(n_rc == c0 + 1 && rb_rd == 8'h3C, "R7", rb_rd, 8'h3C);
    read_rbuf();
    set_cfg(1, 1, 1, 0, 0, 0);
    rx_frame(8'hFF, 1, 1, 0, 0, 0);
    check(rb_rd == 8'h7F, "R7", rb_rd, 8'h7F);
    check(ctrl_rd[10:8] == 3'b000, "R8", ctrl_rd[10:8], 0);
    read_rbuf();

    // parity error: R8 R12
    set_cfg(2, 0, 1, 0, 0, 0);
    e0 = n_err;
    rx_frame(8'h96, 2, 0, 0, 1, 0);
    check(ctrl_rd[9] == 1'b1, "R8", ctrl_rd[9], 1);
    check(n_err == e0 + 1, "R12", n_err - e0, 1);
    read_rbuf();
    // control-word write cannot clear flags: R11
    set_cfg(2, 0, 1, 0, 0, 0);
    check(ctrl_rd == {4'b0101, 7'(cur_cfg)}, "R11", ctrl_rd, {4'b0101, 7'(cur_cfg)});
    setclr(5'b01000);
    check(ctrl_rd[9] == 1'b0, "R11", ctrl_rd[9], 0);
    // parity mismatch ignored when checking is off: R8
    set_cfg(2, 0, 0, 1, 0, 0);
    rx_frame(8'h96, 2, 0, 1, 1, 0);
    check(ctrl_rd[9] == 1'b0 && rb_rd == 8'h96, "R8", ctrl_rd[9], 0);
    read_rbuf();

    // framing error: R9
    set_cfg(0, 0, 0, 0, 0, 0);
    e0 = n_err;
    rx_frame(8'h21, 0, 0, 0, 0, 1);
    check(ctrl_rd[8] == 1'b0 && n_err == e0, "R9", ctrl_rd[8], 0);
    read_rbuf();
    set_cfg(0, 0, 0, 0, 1, 0);
    rx_frame(8'h42, 0, 0, 0, 0, 1);
    check(ctrl_rd[8] == 1'b1 && n_err == e0 + 1, "R9", ctrl_rd[8], 1);
    setclr(5'b00100);
    check(ctrl_rd[8] == 1'b0, "R11", ctrl_rd[8], 0);
    read_rbuf();

    // overrun: R10
    set_cfg(0, 0, 0, 0, 0, 1);
    rx_frame(8'hA1, 0, 0, 0, 0, 0);
    check(ctrl_rd[10] == 1'b0, "R10", ctrl_rd[10], 0);
    rx_frame(8'hB2, 0, 0, 0, 0, 0);
    check(ctrl_rd[10] == 1'b1 && rb_rd == 8'hB2, "R10", {ctrl_rd[10], rb_rd}, 9'h1B2);
    setclr(5'b10000);
    check(ctrl_rd[10] == 1'b0, "R11", ctrl_rd[10], 0);
    read_rbuf();

    // read strobe held through two completions: no overrun, R10
    @(negedge clk);
    rb_re = 1'b1;
    c0 = n_rc;
    rx_frame(8'h5D, 0, 0, 0, 0, 0);
    rx_frame(8'h6E, 0, 0, 0, 0, 0);
    rb_re = 1'b0;
    @(negedge clk);
    check(ctrl_rd[10] == 1'b0 && n_rc == c0 + 2 && rb_rd == 8'h6E, "R10", ctrl_rd[10], 0);

    // receiver off again: R6
    setclr(5'b00010);
    check(ctrl_rd[7] == 1'b0, "R6", ctrl_rd[7], 0);
    c0 = n_rc;
    rx_frame(8'h77, 0, 0, 0, 0, 0);
    check(n_rc == c0 && rb_rd == 8'h6E, "R6", rb_rd, 8'h6E);

    finish_run();
  end
endmodule